// File: doc/BRIEF.md
# Paged Shared-Bus Master Interface

This block connects a local processor port to a shared crate bus that an external arbiter owns. Each processor access falls into one of three address regions. Private local memory is served at once with no wait states. The I/O-module region and the common-memory window go out over the shared bus. Common-memory addresses pass through a 16-entry programmable page table, which swaps the window's page number for a physical page base. A non-local access asks for the bus and holds the processor in wait states until the arbiter grants the bus and the slave acknowledges.

A second path is a channel-style copy engine. Software gives it a local start address, a physical common-memory start address, a word count and a direction. It then copies the block in one burst and keeps the bus request asserted from the first word to the last, so no other master can cut into the transfer. A done flag or an error flag reports how the burst ended.

Top module: `pbb_bridge`

## Requirements
- R1: Address bit 15 = 0 selects local memory, with `loc_addr` = address bits 14:0. Bits 15:14 = 10 select I/O, where `bus_io`=1 and `bus_addr` is address bits 10:0 zero-extended, so bits 13:11 are dropped. Bits 15:14 = 11 select the common window.
- R2: A processor access to local memory while the interface is idle drives `loc_req` in the same cycle, never waits and never raises `bus_req`.
- R3: A common-window address reaches the bus as physical address {table[addr 13:10], addr 9:0}. The 7-bit entry `pt_idx` is loaded with `pt_base` while `pt_we` is high, and every entry is 0 after reset.
- R4: A non-local access raises `bus_req` and keeps `cpu_wait` high until the cycle after `bus_ack`. In that release cycle `cpu_rdata` holds the bus data and `bus_req` is already low. `bus_strobe` is only driven while `bus_req` is high.
- R5: During a burst, `bus_req` stays high without a gap from its first assertion until the last word's acknowledge.
- R6: A burst copies `bx_count` words and increments both addresses by one per word. With `bx_dir`=0 it copies common to local, and with `bx_dir`=1 it copies local to common.
- R7: `bx_busy` is high for the whole burst. `bx_done` rises when the burst ends and stays high until the next accepted start. `bx_done` is never high while busy.
- R8: A `bx_start` pulse while a burst is busy is ignored. The running transfer finishes with its own settings, and the second block's target is not written.
- R9: A start with `bx_count`=0 sets `bx_done` in the next cycle, with no busy period and no bus traffic.
- R10: If `bus_gnt` falls after the bus has been granted during a burst, the engine stops, sets `bx_err`, clears busy, drops `bus_req`, and leaves the rest of the block uncopied.
- R11: While a burst is busy, every processor request waits. If `bx_start` and a non-local processor request arrive in the same idle cycle, the burst goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until wait is low |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | 16 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data |
| cpu_wait | output | 1 | Processor stall |
| loc_req | output | 1 | Local memory access |
| loc_we | output | 1 | Local memory write enable |
| loc_addr | output | 15 | Local memory address |
| loc_wdata | output | 16 | Local memory write data |
| loc_rdata | input | 16 | Local memory read data (combinational) |
| pt_we | input | 1 | Page table write strobe |
| pt_idx | input | 4 | Page table entry index |
| pt_base | input | 7 | Physical page base to store |
| bx_start | input | 1 | Burst start pulse |
| bx_dir | input | 1 | Burst direction: 0 common to local, 1 local to common |
| bx_loc_addr | input | 15 | Burst local start address |
| bx_com_addr | input | 17 | Burst physical common start address |
| bx_count | input | 8 | Burst word count |
| bx_busy | output | 1 | Burst running |
| bx_done | output | 1 | Burst finished (sticky) |
| bx_err | output | 1 | Burst stopped on grant loss (sticky) |
| bus_req | output | 1 | Shared bus request to arbiter |
| bus_gnt | input | 1 | Shared bus grant |
| bus_strobe | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus write |
| bus_io | output | 1 | Bus cycle targets I/O module space |
| bus_addr | output | 17 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_ack | input | 1 | Bus cycle acknowledge |

## Verification
The bench builds the block with its default parameters: 16-bit processor addresses, 16 pages of 1024 words, a 17-bit physical bus address, an 11-bit I/O field and an 8-bit burst counter. This sizing lets both page-table index extremes and the dropped I/O bits be reached in a few cycles. The bench's arbiter grants two cycles after a request, and its slave acknowledges one cycle after a strobe, so each burst word spans several clocks. That spacing lets the grant be withdrawn in the middle of a block and leaves room for a second start and a processor request to land while a transfer is running.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
  typedef enum logic [1:0] {RG_LOCAL, RG_IO, RG_COMMON} region_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARB, ST_CYC, ST_FIN, ST_BARB, ST_BCYC, ST_BWR
  } bst_e;
endpackage

// File: rtl/pbb_decode.sv
module pbb_decode
  import pbb_pkg::*;
#(
  parameter int CPU_AW   = 16,
  parameter int PG_BITS  = 4,
  parameter int OFS_BITS = 10,
  parameter int PHYS_AW  = 17,
  parameter int IO_AW    = 11,
  localparam int LOC_AW  = CPU_AW - 1,
  localparam int BASE_W  = PHYS_AW - OFS_BITS,
  localparam int PG_N    = 1 << PG_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pt_we,
  input  logic [PG_BITS-1:0] pt_idx,
  input  logic [BASE_W-1:0]  pt_base,
  input  logic [CPU_AW-1:0]  addr,
  output region_e            region,
  output logic [LOC_AW-1:0]  loc_addr,
  output logic [PHYS_AW-1:0] phys_addr
);
  logic [BASE_W-1:0]  page_q [PG_N];
  logic [PG_BITS-1:0] page_sel;

  // One register per table entry, each with its own write enable
  for (genvar g = 0; g < PG_N; g++) begin : g_page
    logic en;
    assign en = pt_we && (pt_idx == PG_BITS'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  page_q[g] <= '0;
      else if (en) page_q[g] <= pt_base;
    end
  end

  assign page_sel = addr[OFS_BITS+PG_BITS-1:OFS_BITS];
  assign loc_addr = addr[LOC_AW-1:0];

  always_comb begin
    if (!addr[CPU_AW-1])      region = RG_LOCAL;
    else if (!addr[CPU_AW-2]) region = RG_IO;
    else                      region = RG_COMMON;
    if (region == RG_IO)
      phys_addr = {{(PHYS_AW-IO_AW){1'b0}}, addr[IO_AW-1:0]};
    else
      phys_addr = {page_q[page_sel], addr[OFS_BITS-1:0]};
  end
endmodule

// File: rtl/pbb_burst.sv
module pbb_burst #(
  parameter int LOC_AW  = 15,
  parameter int PHYS_AW = 17,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               cfg_dir,
  input  logic [LOC_AW-1:0]  cfg_loc,
  input  logic [PHYS_AW-1:0] cfg_com,
  input  logic [CNT_W-1:0]   cfg_cnt,
  input  logic               step,
  input  logic               fin_err,
  output logic               dir,
  output logic [LOC_AW-1:0]  loc_ptr,
  output logic [PHYS_AW-1:0] com_ptr,
  output logic               last,
  output logic               done,
  output logic               err
);
  logic               dir_d, done_d, err_d;
  logic [LOC_AW-1:0]  loc_d;
  logic [PHYS_AW-1:0] com_d;
  logic [CNT_W-1:0]   rem_q, rem_d;

  assign last = (rem_q == CNT_W'(1));

  always_comb begin
    dir_d  = dir;
    loc_d  = loc_ptr;
    com_d  = com_ptr;
    rem_d  = rem_q;
    done_d = done;
    err_d  = err;
    if (load) begin
      dir_d  = cfg_dir;
      loc_d  = cfg_loc;
      com_d  = cfg_com;
      rem_d  = cfg_cnt;
      done_d = (cfg_cnt == '0);
      err_d  = 1'b0;
    end else begin
      if (step) begin
        loc_d = loc_ptr + LOC_AW'(1);
        com_d = com_ptr + PHYS_AW'(1);
        rem_d = rem_q - CNT_W'(1);
        if (last) done_d = 1'b1;
      end
      if (fin_err) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir     <= 1'b0;
      loc_ptr <= '0;
      com_ptr <= '0;
      rem_q   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      dir     <= dir_d;
      loc_ptr <= loc_d;
      com_ptr <= com_d;
      rem_q   <= rem_d;
      done    <= done_d;
      err     <= err_d;
    end
  end
endmodule

// File: rtl/pbb_bridge.sv
module pbb_bridge
  import pbb_pkg::*;
#(
  parameter int CPU_AW   = 16,
  parameter int DW       = 16,
  parameter int PG_BITS  = 4,
  parameter int OFS_BITS = 10,
  parameter int PHYS_AW  = 17,
  parameter int IO_AW    = 11,
  parameter int CNT_W    = 8,
  localparam int LOC_AW  = CPU_AW - 1,
  localparam int BASE_W  = PHYS_AW - OFS_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [DW-1:0]      cpu_wdata,
  output logic [DW-1:0]      cpu_rdata,
  output logic               cpu_wait,
  output logic               loc_req,
  output logic               loc_we,
  output logic [LOC_AW-1:0]  loc_addr,
  output logic [DW-1:0]      loc_wdata,
  input  logic [DW-1:0]      loc_rdata,
  input  logic               pt_we,
  input  logic [PG_BITS-1:0] pt_idx,
  input  logic [BASE_W-1:0]  pt_base,
  input  logic               bx_start,
  input  logic               bx_dir,
  input  logic [LOC_AW-1:0]  bx_loc_addr,
  input  logic [PHYS_AW-1:0] bx_com_addr,
  input  logic [CNT_W-1:0]   bx_count,
  output logic               bx_busy,
  output logic               bx_done,
  output logic               bx_err,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic               bus_strobe,
  output logic               bus_we,
  output logic               bus_io,
  output logic [PHYS_AW-1:0] bus_addr,
  output logic [DW-1:0]      bus_wdata,
  input  logic [DW-1:0]      bus_rdata,
  input  logic               bus_ack
);
  bst_e               st_q, st_d;
  logic [DW-1:0]      data_q, data_d;
  region_e            rg;
  logic [LOC_AW-1:0]  cpu_loc;
  logic [PHYS_AW-1:0] cpu_phys;
  logic               cpu_is_local, is_idle;
  logic               ld, step, fin_err, b_dir, b_last;
  logic [LOC_AW-1:0]  b_loc;
  logic [PHYS_AW-1:0] b_com;

  pbb_decode #(
    .CPU_AW(CPU_AW), .PG_BITS(PG_BITS), .OFS_BITS(OFS_BITS),
    .PHYS_AW(PHYS_AW), .IO_AW(IO_AW)
  ) dec_i (
    .clk(clk), .rst_n(rst_n), .pt_we(pt_we), .pt_idx(pt_idx),
    .pt_base(pt_base), .addr(cpu_addr), .region(rg),
    .loc_addr(cpu_loc), .phys_addr(cpu_phys)
  );

  pbb_burst #(.LOC_AW(LOC_AW), .PHYS_AW(PHYS_AW), .CNT_W(CNT_W)) bst_i (
    .clk(clk), .rst_n(rst_n), .load(ld), .cfg_dir(bx_dir),
    .cfg_loc(bx_loc_addr), .cfg_com(bx_com_addr), .cfg_cnt(bx_count),
    .step(step), .fin_err(fin_err), .dir(b_dir), .loc_ptr(b_loc),
    .com_ptr(b_com), .last(b_last), .done(bx_done), .err(bx_err)
  );

  assign cpu_is_local = (rg == RG_LOCAL);
  assign is_idle      = (st_q == ST_IDLE);
  assign bx_busy      = (st_q == ST_BARB) || (st_q == ST_BCYC) || (st_q == ST_BWR);
  assign ld           = is_idle && bx_start;
  assign fin_err      = ((st_q == ST_BCYC) || (st_q == ST_BWR)) && !bus_gnt;
  assign step         = ((st_q == ST_BCYC) && bus_gnt && bus_ack && b_dir) ||
                        ((st_q == ST_BWR) && bus_gnt);

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    data_d = data_q;
    unique case (st_q)
      ST_IDLE: begin
        if (bx_start) begin
          if (bx_count != '0) st_d = ST_BARB;
        end else if (cpu_req && !cpu_is_local) begin
          st_d = ST_ARB;
        end
      end
      ST_ARB:  if (bus_gnt) st_d = ST_CYC;
      ST_CYC: begin
        if (bus_ack) begin
          data_d = bus_rdata;
          st_d   = ST_FIN;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      ST_BARB: if (bus_gnt) st_d = ST_BCYC;
      ST_BCYC: begin
        if (!bus_gnt) st_d = ST_IDLE;
        else if (bus_ack) begin
          if (!b_dir) begin
            data_d = bus_rdata;
            st_d   = ST_BWR;
          end else if (b_last) begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_BWR: begin
        if (!bus_gnt || b_last) st_d = ST_IDLE;
        else                    st_d = ST_BCYC;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      data_q <= data_d;
    end
  end

  // Processor side
  assign cpu_wait  = cpu_req && (st_q != ST_FIN) && !(is_idle && cpu_is_local);
  assign cpu_rdata = (st_q == ST_FIN) ? data_q : loc_rdata;

  // Local memory port: owned by the engine while a burst runs
  always_comb begin
    if (bx_busy) begin
      loc_req   = (st_q == ST_BWR) || ((st_q == ST_BCYC) && b_dir);
      loc_we    = (st_q == ST_BWR);
      loc_addr  = b_loc;
      loc_wdata = data_q;
    end else begin
      loc_req   = cpu_req && cpu_is_local && is_idle;
      loc_we    = cpu_we;
      loc_addr  = cpu_loc;
      loc_wdata = cpu_wdata;
    end
  end

  // Shared bus side
  assign bus_req    = (st_q == ST_ARB) || (st_q == ST_CYC) || bx_busy;
  assign bus_strobe = (st_q == ST_CYC) || (st_q == ST_BCYC);
  always_comb begin
    if (st_q == ST_CYC) begin
      bus_we    = cpu_we;
      bus_io    = (rg == RG_IO);
      bus_addr  = cpu_phys;
      bus_wdata = cpu_wdata;
    end else begin
      bus_we    = (st_q == ST_BCYC) && b_dir;
      bus_io    = 1'b0;
      bus_addr  = b_com;
      bus_wdata = loc_rdata;
    end
  end
endmodule

// File: rtl/pbb_bridge_chk.sv
module pbb_bridge_chk #(
  parameter int PHYS_AW = 17,
  parameter int IO_AW   = 11,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req,
  input logic               cpu_is_local,
  input logic               cpu_wait,
  input logic               is_idle,
  input logic               bx_start,
  input logic [CNT_W-1:0]   bx_count,
  input logic               bx_busy,
  input logic               bx_done,
  input logic               bx_err,
  input logic               bus_req,
  input logic               bus_strobe,
  input logic               bus_io,
  input logic [PHYS_AW-1:0] bus_addr
);
  assert_io_addr_narrow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_io) |-> (bus_addr[PHYS_AW-1:IO_AW] == '0));

  assert_local_no_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_is_local && is_idle) |-> (!cpu_wait && !bus_req));

  assert_strobe_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> bus_req);

  assert_burst_holds_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req) && $past(bx_busy) && bx_busy) |-> bus_req);

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bx_busy |-> !bx_done);

  assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && bx_start && bx_count == '0) |=> (bx_done && !bx_busy));

  assert_err_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bx_busy) && !bx_busy && bx_err) |-> !bus_req);

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bx_done && bx_err));
endmodule

bind pbb_bridge pbb_bridge_chk #(.PHYS_AW(PHYS_AW), .IO_AW(IO_AW), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_is_local(cpu_is_local),
  .cpu_wait(cpu_wait), .is_idle(is_idle), .bx_start(bx_start),
  .bx_count(bx_count), .bx_busy(bx_busy), .bx_done(bx_done), .bx_err(bx_err),
  .bus_req(bus_req), .bus_strobe(bus_strobe), .bus_io(bus_io),
  .bus_addr(bus_addr)
);

// File: tb/pbb_bridge_tb.sv
module pbb_bridge_tb_top;
  localparam int GNT_DLY = 2;
  localparam int ACK_DLY = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [15:0] cpu_addr = 0, cpu_wdata = 0;
  logic [15:0] cpu_rdata;
  logic        cpu_wait;
  logic        loc_req, loc_we;
  logic [14:0] loc_addr;
  logic [15:0] loc_wdata, loc_rdata;
  logic        pt_we = 0;
  logic [3:0]  pt_idx = 0;
  logic [6:0]  pt_base = 0;
  logic        bx_start = 0, bx_dir = 0;
  logic [14:0] bx_loc_addr = 0;
  logic [16:0] bx_com_addr = 0;
  logic [7:0]  bx_count = 0;
  logic        bx_busy, bx_done, bx_err;
  logic        bus_req, bus_strobe, bus_we, bus_io;
  logic        bus_gnt = 0, bus_ack = 0;
  logic [16:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata = 0;

  int n_chk = 0, n_fail = 0;
  logic drop_gnt = 0;
  int gcnt = 0, acnt = 0;
  logic prev_hold = 0;
  int bus_seen = 0;

  logic [15:0] lmem [1024];
  logic [15:0] cmem [int];
  logic [15:0] iomem [int];

  always #5 clk = ~clk;

  pbb_bridge dut_i (.*);

  assign loc_rdata = lmem[loc_addr[9:0]];

  function automatic logic [15:0] crd(int a);
    return cmem.exists(a) ? cmem[a] : 16'h0;
  endfunction
  function automatic logic [15:0] ird(int a);
    return iomem.exists(a) ? iomem[a] : 16'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural memories, arbiter and slave, all acting on the falling edge
  always @(negedge clk) begin
    if (loc_req && loc_we) lmem[loc_addr[9:0]] <= loc_wdata;
    if (!bus_req || drop_gnt) begin
      bus_gnt <= 1'b0; gcnt <= 0;
    end else if (!bus_gnt) begin
      if (gcnt >= GNT_DLY) bus_gnt <= 1'b1; else gcnt <= gcnt + 1;
    end
    if (bus_strobe && !bus_ack && acnt >= ACK_DLY) begin
      bus_ack <= 1'b1; acnt <= 0;
      if (bus_we) begin
        if (bus_io) iomem[int'(bus_addr)] = bus_wdata;
        else        cmem[int'(bus_addr)]  = bus_wdata;
      end else begin
        bus_rdata <= bus_io ? ird(int'(bus_addr)) : crd(int'(bus_addr));
      end
    end else begin
      bus_ack <= 1'b0;
      if (bus_strobe && !bus_ack) acnt <= acnt + 1;
    end
    if (bus_req) bus_seen++;
  end

  // Per-clock model of the bus-holding rule during bursts (R5)
  always @(negedge clk) begin
    if (rst_n) begin
      if (bx_busy && prev_hold && !drop_gnt) chk("R5 bus_req held in burst", bus_req, 1'b1);
      prev_hold <= bx_busy && bus_req;
    end
  end

  task automatic cpu_access(input logic we, input logic [15:0] a, input logic [15:0] wd,
                            output logic [15:0] rd, output int waits);
    waits = 0;
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    forever begin
      @(negedge clk); #1;
      if (!cpu_wait) break;
      waits++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic pt_write(input logic [3:0] i, input logic [6:0] b);
    @(posedge clk); #1; pt_we = 1; pt_idx = i; pt_base = b;
    @(posedge clk); #1; pt_we = 0;
  endtask

  task automatic bx_go(input logic d, input logic [14:0] la, input logic [16:0] ca,
                       input logic [7:0] n);
    @(posedge clk); #1;
    bx_start = 1; bx_dir = d; bx_loc_addr = la; bx_com_addr = ca; bx_count = n;
    @(posedge clk); #1; bx_start = 0;
  endtask

  task automatic bx_wait();
    @(negedge clk); #1;
    while (bx_busy) begin @(negedge clk); #1; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R4 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int w, seen0;
    for (int i = 0; i < 1024; i++) lmem[i] = 16'h0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk); #1;
    // Reset state
    chk("R4 reset bus_req", bus_req, 0);
    chk("R7 reset busy/done/err", {bx_busy, bx_done, bx_err}, 3'b000);
    chk("R4 reset cpu_wait", cpu_wait, 0);

    // R1/R2: local write and read, zero waits and no bus traffic
    seen0 = bus_seen;
    cpu_access(1, 16'h0012, 16'hCAFE, rd, w);
    chk("R2 local write waits", w, 0);
    chk("R1 local write lands at addr[14:0]", lmem[12'h012], 16'hCAFE);
    cpu_access(0, 16'h0012, 16'h0, rd, w);
    chk("R2 local read data", rd, 16'hCAFE);
    chk("R2 local no bus_req", bus_seen - seen0, 0);

    // R3: reset page table maps every page to base 0
    cmem[3] = 16'h1234;
    cpu_access(0, 16'hC000 | (16'd2 << 10) | 16'd3, 0, rd, w);
    chk("R3 reset table entry 0", rd, 16'h1234);
    chk("R4 nonlocal read stalled", w >= 2, 1);
    chk("R4 bus_req low after release", bus_req, 0);

    // R3: programmed entries, including both index extremes
    pt_write(4'd5, 7'h3A);
    pt_write(4'd15, 7'h7F);
    pt_write(4'd0, 7'h01);
    cmem[(32'h3A << 10) | 7] = 16'hBEEF;
    cpu_access(0, 16'hD407, 0, rd, w);
    chk("R3 page 5 read", rd, 16'hBEEF);
    cpu_access(1, 16'hFC21, 16'h5151, rd, w);
    chk("R3 page 15 write", crd((32'h7F << 10) | 32'h21), 16'h5151);
    cpu_access(1, 16'hC004, 16'h6060, rd, w);
    chk("R3 page 0 write", crd((32'h01 << 10) | 4), 16'h6060);

    // R1: I/O region, bits 13:11 dropped
    cpu_access(1, 16'hB9AB, 16'h7777, rd, w);
    chk("R1 io write address", ird(32'h1AB), 16'h7777);
    chk("R4 io write stalled", w >= 2, 1);
    cpu_access(0, 16'h81AB, 0, rd, w);
    chk("R1 io read back", rd, 16'h7777);

    // R6/R7: common to local, 5 words
    for (int i = 0; i < 5; i++) cmem[32'h0400 + i] = 16'hA100 + 16'(i);
    bx_go(0, 15'h0100, 17'h00400, 8'd5);
    chk("R7 busy after start", bx_busy, 1);
    chk("R7 done low while busy", bx_done, 0);
    bx_wait();
    chk("R7 done after burst", bx_done, 1);
    for (int i = 0; i < 5; i++) chk("R6 common to local word", lmem[10'h100 + i], 16'hA100 + 16'(i));
    chk("R6 no extra word", lmem[10'h105], 16'h0);

    // R6: local to common, 4 words
    for (int i = 0; i < 4; i++) lmem[10'h040 + i] = 16'hB200 + 16'(i);
    bx_go(1, 15'h0040, 17'h10800, 8'd4);
    bx_wait();
    for (int i = 0; i < 4; i++) chk("R6 local to common word", crd(32'h10800 + i), 16'hB200 + 16'(i));
    chk("R6 no extra common word", crd(32'h10804), 16'h0);

    // R8 and R11: second start and a processor request during a busy burst
    for (int i = 0; i < 6; i++) cmem[32'h0600 + i] = 16'hC300 + 16'(i);
    lmem[10'h050] = 16'hD00D;
    bx_go(0, 15'h0200, 17'h00600, 8'd6);
    repeat (3) @(posedge clk); #1;
    bx_start = 1; bx_dir = 1; bx_loc_addr = 15'h0050; bx_com_addr = 17'h00900; bx_count = 8'd3;
    @(posedge clk); #1; bx_start = 0;
    cpu_req = 1; cpu_we = 0; cpu_addr = 16'h0050;
    @(negedge clk); #1;
    chk("R11 local access waits during burst", cpu_wait, 1);
    chk("R11 engine owns local port", loc_addr == 15'h0050, 0);
    bx_wait();
    chk("R11 local access released after burst", cpu_wait, 0);
    chk("R11 local read data", cpu_rdata, 16'hD00D);
    @(posedge clk); #1; cpu_req = 0;
    for (int i = 0; i < 6; i++) chk("R8 first burst intact", lmem[10'h200 + i], 16'hC300 + 16'(i));
    chk("R8 second target untouched", crd(32'h00900), 16'h0);

    // R11 priority: burst and nonlocal processor request in the same idle cycle
    iomem[5] = 16'h4242;
    lmem[10'h010] = 16'hE001; lmem[10'h011] = 16'hE002;
    @(posedge clk); #1;
    bx_start = 1; bx_dir = 1; bx_loc_addr = 15'h0010; bx_com_addr = 17'h00500; bx_count = 8'd2;
    cpu_req = 1; cpu_we = 0; cpu_addr = 16'h8005;
    @(posedge clk); #1; bx_start = 0;
    @(negedge clk); #1;
    chk("R11 burst wins arbitration", bx_busy, 1);
    chk("R11 cpu waits", cpu_wait, 1);
    bx_wait();
    while (cpu_wait) begin @(negedge clk); #1; end
    chk("R11 cpu read after burst", cpu_rdata, 16'h4242);
    @(posedge clk); #1; cpu_req = 0;
    chk("R6 priority burst word", crd(32'h00501), 16'hE002);

    // R10: grant withdrawn mid-burst
    for (int i = 0; i < 8; i++) cmem[32'h2000 + i] = 16'hF000 + 16'(i);
    bx_go(0, 15'h0300, 17'h02000, 8'd8);
    repeat (6) @(negedge clk);
    drop_gnt = 1;
    bx_wait();
    chk("R10 err set", bx_err, 1);
    chk("R10 done not set", bx_done, 0);
    chk("R10 bus released", bus_req, 0);
    chk("R10 tail word not copied", lmem[10'h307], 16'h0);
    chk("R10 first word copied", lmem[10'h300], 16'hF000);
    @(posedge clk); #1; drop_gnt = 0;

    // R9: zero-length burst
    seen0 = bus_seen;
    bx_go(0, 15'h0380, 17'h03000, 8'd0);
    @(negedge clk); #1;
    chk("R9 done at once", bx_done, 1);
    chk("R9 not busy", bx_busy, 0);
    chk("R9 err cleared by start", bx_err, 0);
    repeat (3) @(negedge clk);
    chk("R9 no bus traffic", bus_seen - seen0, 0);

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule